// File: doc/BRIEF.md
# Privileged Register Access Trap Router

This block decides what happens when software at a given privilege level tries to read or write one performance-monitor control register. It takes the current privilege level (0 to 3), the access direction, the debug state and the relevant trap-control bits, and returns one of three outcomes: the access is allowed, it is undefined, or it traps. A trap comes with a target privilege level and an 8-bit syndrome class. The register itself is stored elsewhere. This block only gives the verdict.

The checks run in a fixed priority that depends on the privilege level, and the first check that matches decides the outcome. Level 3 is never blocked. Level 2 is checked only against the level-3 controls. Levels 0 and 1 also face the user-enable check (level 0 only), the fine-grained read/write traps and the level-2 monitor trap. The verdict is registered, so it appears one clock after the inputs are presented.

Top module: `acc_trap_router`

## Requirements
- R1: With priv_lvl = 3 the verdict is allowed, whatever the other inputs are.
- R2: At levels 0 to 2, if the build option HALT_L3_FIRST is 1 and dbg_halted, sec_dbg_off, has_lvl3 and mon_trap_l3 are all 1, the verdict is undefined.
- R3: At level 0 with user_en = 0, the access traps. The target is level 2 when has_lvl2, lvl2_active and tge are all 1, and level 1 otherwise.
- R4: At levels 0 and 1, a fine-grained trap to level 2 occurs when level 2 is present and enabled, level 3 is absent or fgt_en_l3 = 1, and the selected bit is set. The selected bit is fgt_rd when is_write = 0 and fgt_wr when is_write = 1.
- R5: At level 0 the fine-grained trap is suppressed when host_ext and tge are both 1.
- R6: At levels 0 and 1, mon_trap_l2 = 1 with level 2 present and enabled traps to level 2.
- R7: As the last check, mon_trap_l3 = 1 with has_lvl3 = 1 traps to level 3. If dbg_halted and sec_dbg_off are both 1, the verdict is undefined instead.
- R8: At level 2 the user-enable, fine-grained and level-2 monitor checks are skipped.
- R9: Exactly one of allowed, undefined and trap is 1. When the verdict is trap, syn_class = 0x18. Otherwise trap_lvl and syn_class are 0.
- R10: The verdict appears on the outputs after the next rising clock edge. While reset is held (rst_n = 0) the outputs show allowed, with a target of 0 and a syndrome of 0.
- R11: When several checks match at once, the earlier one in the order R2, R3, R4, R6, R7 decides the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| is_write | input | 1 | 1 = write access, 0 = read access |
| dbg_halted | input | 1 | Core is halted in debug |
| sec_dbg_off | input | 1 | Secure debug is disabled |
| has_lvl2 | input | 1 | Privilege level 2 is implemented |
| has_lvl3 | input | 1 | Privilege level 3 is implemented |
| lvl2_active | input | 1 | Level 2 is enabled in the current security state |
| user_en | input | 1 | Level-0 access enable |
| tge | input | 1 | Route general exceptions to level 2 |
| host_ext | input | 1 | Host extension mode |
| fgt_en_l3 | input | 1 | Level 3 permits fine-grained traps |
| fgt_rd | input | 1 | Fine-grained read trap bit |
| fgt_wr | input | 1 | Fine-grained write trap bit |
| mon_trap_l2 | input | 1 | Level-2 monitor trap bit |
| mon_trap_l3 | input | 1 | Level-3 monitor trap bit |
| res_allow | output | 1 | Access is allowed |
| res_undef | output | 1 | Access is undefined |
| res_trap | output | 1 | Access traps |
| trap_lvl | output | 2 | Trap target level, valid only with res_trap |
| syn_class | output | 8 | Syndrome class, valid only with res_trap |

## Verification
The main hazard is two checks matching in the same cycle. Examples are a cleared user enable together with a set fine-grained bit, or a halted secure-debug state together with a level-3 monitor trap that would otherwise route normally. The bench builds these overlaps on purpose, both in directed vectors and by sweeping all 65536 input combinations. Each verdict is compared with a reference model written from the priority list, so the check that wins can be seen from both the outcome and the target level.

// File: rtl/acc_trap_pkg.sv
package acc_trap_pkg;

    localparam int LVL_W = 2;

    typedef struct packed {
        logic             pre_undef;
        logic             usr_trap;
        logic [LVL_W-1:0] usr_tgt;
        logic             fg_trap;
        logic             mt2_trap;
        logic             mt3_hit;
        logic             mt3_undef;
    } hits_t;

    typedef struct packed {
        logic             allow;
        logic             undef;
        logic             trap;
        logic [LVL_W-1:0] tgt;
    } verdict_t;

endpackage

// File: rtl/acc_trap_checks.sv
module acc_trap_checks
    import acc_trap_pkg::*;
#(
    parameter bit HALT_L3_FIRST = 1'b1
) (
    input  logic [LVL_W-1:0] priv_lvl,
    input  logic             is_write,
    input  logic             dbg_halted,
    input  logic             sec_dbg_off,
    input  logic             has_lvl2,
    input  logic             has_lvl3,
    input  logic             lvl2_active,
    input  logic             user_en,
    input  logic             tge,
    input  logic             host_ext,
    input  logic             fgt_en_l3,
    input  logic             fgt_rd,
    input  logic             fgt_wr,
    input  logic             mon_trap_l2,
    input  logic             mon_trap_l3,
    output hits_t            hits
);

    logic l2_on;
    logic fg_bit;
    logic fg_gate;
    logic halt_sec;
    logic pre_hit;

    assign l2_on    = has_lvl2 & lvl2_active;
    assign halt_sec = dbg_halted & sec_dbg_off;

    // Build-time choice: whether the halted level-3 condition is checked first
    generate
        if (HALT_L3_FIRST) begin : g_pre_on
            assign pre_hit = halt_sec & has_lvl3 & mon_trap_l3;
        end else begin : g_pre_off
            assign pre_hit = 1'b0;
        end
    endgenerate

    assign fg_bit  = is_write ? fgt_wr : fgt_rd;
    assign fg_gate = l2_on & (~has_lvl3 | fgt_en_l3)
                   & ((priv_lvl != 2'd0) | ~(host_ext & tge));

    always_comb begin
        hits           = '0;
        hits.pre_undef = pre_hit;
        hits.usr_trap  = ~user_en;
        hits.usr_tgt   = (l2_on & tge) ? 2'd2 : 2'd1;
        hits.fg_trap   = fg_gate & fg_bit;
        hits.mt2_trap  = l2_on & mon_trap_l2;
        hits.mt3_hit   = has_lvl3 & mon_trap_l3;
        hits.mt3_undef = halt_sec;
    end

endmodule

// File: rtl/acc_trap_prio.sv
module acc_trap_prio
    import acc_trap_pkg::*;
(
    input  logic [LVL_W-1:0] priv_lvl,
    input  hits_t            hits,
    output verdict_t         verdict
);

    logic low_lvl;

    assign low_lvl = (priv_lvl == 2'd0) | (priv_lvl == 2'd1);

    always_comb begin
        verdict       = '0;
        verdict.allow = 1'b1;
        if (priv_lvl == 2'd3) begin
            verdict.allow = 1'b1;
        end else if (hits.pre_undef) begin
            verdict.allow = 1'b0;
            verdict.undef = 1'b1;
        end else if ((priv_lvl == 2'd0) && hits.usr_trap) begin
            verdict.allow = 1'b0;
            verdict.trap  = 1'b1;
            verdict.tgt   = hits.usr_tgt;
        end else if (low_lvl && hits.fg_trap) begin
            verdict.allow = 1'b0;
            verdict.trap  = 1'b1;
            verdict.tgt   = 2'd2;
        end else if (low_lvl && hits.mt2_trap) begin
            verdict.allow = 1'b0;
            verdict.trap  = 1'b1;
            verdict.tgt   = 2'd2;
        end else if (hits.mt3_hit) begin
            verdict.allow = 1'b0;
            if (hits.mt3_undef) begin
                verdict.undef = 1'b1;
            end else begin
                verdict.trap = 1'b1;
                verdict.tgt  = 2'd3;
            end
        end
    end

endmodule

// File: rtl/acc_trap_router.sv
module acc_trap_router
    import acc_trap_pkg::*;
#(
    parameter bit       HALT_L3_FIRST = 1'b1,
    parameter int       SYN_W         = 8,
    parameter bit [7:0] SYN_CODE      = 8'h18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       priv_lvl,
    input  logic             is_write,
    input  logic             dbg_halted,
    input  logic             sec_dbg_off,
    input  logic             has_lvl2,
    input  logic             has_lvl3,
    input  logic             lvl2_active,
    input  logic             user_en,
    input  logic             tge,
    input  logic             host_ext,
    input  logic             fgt_en_l3,
    input  logic             fgt_rd,
    input  logic             fgt_wr,
    input  logic             mon_trap_l2,
    input  logic             mon_trap_l3,
    output logic             res_allow,
    output logic             res_undef,
    output logic             res_trap,
    output logic [1:0]       trap_lvl,
    output logic [SYN_W-1:0] syn_class
);

    typedef struct packed {
        verdict_t         vd;
        logic [SYN_W-1:0] syn;
    } out_t;

    localparam out_t OUT_RST = '{vd: '{allow: 1'b1, undef: 1'b0, trap: 1'b0, tgt: '0}, syn: '0};

    hits_t    hits;
    verdict_t verdict;
    out_t     out_d, out_q;

    acc_trap_checks #(.HALT_L3_FIRST(HALT_L3_FIRST)) u_checks (
        .priv_lvl    (priv_lvl),
        .is_write    (is_write),
        .dbg_halted  (dbg_halted),
        .sec_dbg_off (sec_dbg_off),
        .has_lvl2    (has_lvl2),
        .has_lvl3    (has_lvl3),
        .lvl2_active (lvl2_active),
        .user_en     (user_en),
        .tge         (tge),
        .host_ext    (host_ext),
        .fgt_en_l3   (fgt_en_l3),
        .fgt_rd      (fgt_rd),
        .fgt_wr      (fgt_wr),
        .mon_trap_l2 (mon_trap_l2),
        .mon_trap_l3 (mon_trap_l3),
        .hits        (hits)
    );

    acc_trap_prio u_prio (
        .priv_lvl (priv_lvl),
        .hits     (hits),
        .verdict  (verdict)
    );

    always_comb begin
        out_d     = '0;
        out_d.vd  = verdict;
        out_d.syn = verdict.trap ? SYN_W'(SYN_CODE) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= OUT_RST;
        else        out_q <= out_d;
    end

    assign res_allow = out_q.vd.allow;
    assign res_undef = out_q.vd.undef;
    assign res_trap  = out_q.vd.trap;
    assign trap_lvl  = out_q.vd.tgt;
    assign syn_class = out_q.syn;

    // R1: level 3 is never blocked
    a_r1_l3_allow: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_lvl == 2'd3) |=> res_allow);

    // R8: at level 2 only level-3 controls can block
    a_r8_l2_skip: assert property (@(posedge clk) disable iff (!rst_n)
        ((priv_lvl == 2'd2) && !(has_lvl3 && mon_trap_l3)) |=> res_allow);

    // R2 / R7: undefined only arises from the halted secure-debug level-3 case
    a_r7_undef_src: assert property (@(posedge clk) disable iff (!rst_n)
        res_undef |-> $past(dbg_halted && sec_dbg_off && has_lvl3 && mon_trap_l3));

    // R9: outcomes mutually exclusive and complete
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({res_allow, res_undef, res_trap}) == 1);

    // R9: target and syndrome only meaningful on a trap
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !res_trap |-> (trap_lvl == 2'd0 && syn_class == '0));

    // R9: trap carries the syndrome class and a non-zero target
    a_r9_trap_syn: assert property (@(posedge clk) disable iff (!rst_n)
        res_trap |-> (syn_class == SYN_W'(SYN_CODE) && trap_lvl != 2'd0));

endmodule

// File: tb/sim_acc_trap_router.sv
module sim_acc_trap_router;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] priv_lvl;
    logic       is_write, dbg_halted, sec_dbg_off, has_lvl2, has_lvl3, lvl2_active;
    logic       user_en, tge, host_ext, fgt_en_l3, fgt_rd, fgt_wr, mon_trap_l2, mon_trap_l3;
    logic       res_allow, res_undef, res_trap;
    logic [1:0] trap_lvl;
    logic [7:0] syn_class;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    acc_trap_router u0 (
        .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .is_write(is_write),
        .dbg_halted(dbg_halted), .sec_dbg_off(sec_dbg_off), .has_lvl2(has_lvl2),
        .has_lvl3(has_lvl3), .lvl2_active(lvl2_active), .user_en(user_en), .tge(tge),
        .host_ext(host_ext), .fgt_en_l3(fgt_en_l3), .fgt_rd(fgt_rd), .fgt_wr(fgt_wr),
        .mon_trap_l2(mon_trap_l2), .mon_trap_l3(mon_trap_l3), .res_allow(res_allow),
        .res_undef(res_undef), .res_trap(res_trap), .trap_lvl(trap_lvl), .syn_class(syn_class)
    );

    // stim: priv[15:14] wr halt sdd | h2 h3 l2act | uen tge e2h | fgten fgrd fgwr | mt2 mt3
    // exp : {kind[1:0], lvl[1:0]}, kind 00 allow, 01 undef, 10 trap
    localparam logic [23:0] VEC [15] = '{
        {4'd1,  16'b11_1_11_111_111_111_11, 4'b00_00},  // R1
        {4'd3,  16'b00_0_00_101_010_000_00, 4'b10_10},  // R3 to level 2
        {4'd3,  16'b00_0_00_101_000_000_00, 4'b10_01},  // R3 to level 1
        {4'd11, 16'b00_0_11_010_000_000_01, 4'b01_00},  // R11 / R2 beats user trap
        {4'd4,  16'b01_0_00_101_100_010_00, 4'b10_10},  // R4 read bit
        {4'd4,  16'b01_1_00_101_100_010_00, 4'b00_00},  // R4 write ignores read bit
        {4'd4,  16'b01_1_00_111_100_001_00, 4'b00_00},  // R4 level 3 blocks
        {4'd5,  16'b00_0_00_101_111_010_00, 4'b00_00},  // R5
        {4'd6,  16'b01_0_00_101_100_000_10, 4'b10_10},  // R6
        {4'd8,  16'b10_0_00_101_000_010_10, 4'b00_00},  // R8
        {4'd7,  16'b10_0_00_010_000_000_01, 4'b10_11},  // R7 trap to 3
        {4'd2,  16'b10_0_11_010_000_000_01, 4'b01_00},  // R2 at level 2
        {4'd7,  16'b01_0_10_010_100_000_01, 4'b10_11},  // R7 halted only
        {4'd6,  16'b01_0_00_001_100_000_10, 4'b00_00},  // R6 level 2 absent
        {4'd11, 16'b00_0_00_101_000_010_00, 4'b10_01}   // R11 user beats fine-grained
    };

    function automatic logic [3:0] ref_model(input logic [15:0] s);
        logic [1:0] p;
        logic l2on, fgb;
        p    = s[15:14];
        l2on = s[10] & s[8];
        fgb  = s[13] ? s[2] : s[3];
        if (p == 2'd3) return 4'b00_00;
        if (s[12] && s[11] && s[9] && s[0]) return 4'b01_00;
        if (p == 2'd0 && !s[7]) return (l2on && s[6]) ? 4'b10_10 : 4'b10_01;
        if (p != 2'd2) begin
            if (l2on && (!s[9] || s[4]) && fgb && !(p == 2'd0 && s[5] && s[6])) return 4'b10_10;
            if (l2on && s[1]) return 4'b10_10;
        end
        if (s[9] && s[0]) return (s[12] && s[11]) ? 4'b01_00 : 4'b10_11;
        return 4'b00_00;
    endfunction

    task automatic drive(input logic [15:0] s);
        priv_lvl    = s[15:14]; is_write  = s[13]; dbg_halted = s[12]; sec_dbg_off = s[11];
        has_lvl2    = s[10];    has_lvl3  = s[9];  lvl2_active = s[8]; user_en    = s[7];
        tge         = s[6];     host_ext  = s[5];  fgt_en_l3  = s[4];  fgt_rd     = s[3];
        fgt_wr      = s[2];     mon_trap_l2 = s[1]; mon_trap_l3 = s[0];
    endtask

    task automatic compare(input int req, input logic [3:0] exp);
        logic [3:0] act_v, exp_v;
        logic [7:0] exp_syn;
        act_v   = {res_trap, res_undef, trap_lvl};
        exp_v   = exp;
        exp_syn = (exp[3:2] == 2'b10) ? 8'h18 : 8'h00;
        n_chk++;
        if (act_v != exp_v || syn_class != exp_syn ||
            res_allow != (exp[3:2] == 2'b00)) begin
            n_fail++;
            $display("FAIL R%0d: trap/undef/lvl=%b allow=%b syn=%h, expected %b syn=%h",
                     req, act_v, res_allow, syn_class, exp_v, exp_syn);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        drive(16'hFFFF);
        repeat (3) @(negedge clk);
        // R10: reset state shows allowed with zero target and syndrome
        compare(10, 4'b00_00);
        rst_n = 1'b1;
        // R10: result after one edge
        drive(16'b00_0_00_101_000_000_00);
        @(negedge clk);
        compare(10, 4'b10_01);

        for (int i = 0; i < 15; i++) begin
            drive(VEC[i][19:4]);
            @(negedge clk);
            compare(int'(VEC[i][23:20]), VEC[i][3:0]);
        end

        // R9 and the overlap cases: every input combination against the reference
        for (int i = 0; i < 65536; i++) begin
            drive(16'(i));
            @(negedge clk);
            compare(9, ref_model(16'(i)));
        end

        // R10: reset reasserted returns to the reset state
        drive(16'b00_0_00_101_000_000_00);
        rst_n = 1'b0;
        @(negedge clk);
        compare(10, 4'b00_00);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10: watchdog expired, actual hung, expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule